// File: doc/BRIEF.md
# Subcarrier-Locked System Clock Divider

This block runs on a master clock at six times the colour subcarrier and produces the three-times-subcarrier system clock as a divided level plus a one-cycle enable. On every second video line, marked by the horizontal sync detector, it freezes the divide-by-two for one master cycle. That shifts the system clock by half a period and keeps the sample grid aligned across lines, even though the subcarrier is not a whole multiple of the line rate.

The block also keeps a line index and an odd/even line flag. From these it drives start strobes for the line stores that delay the video by two and by four lines. A rising edge on vertical sync arms a field resync. The next horizontal sync edge then clears the line flag and the line index, so the line-start pattern cannot drift across fields. When the run-enable from the mode controller is low (bypass), the divider, the line state and all strobes are held inactive. After the run-enable rises, no strobe is issued until the first field resync has taken place.

Top module: `subcarrier_clk_div`

## Requirements
- R1: In reset, and one clock after any cycle with `run_i` low, `cl3_o`, `odd_line_o` and `line_start_o` are zero. `cl3_en_o` is zero in every cycle in which `run_i` is low.
- R2: With `run_i` high and no correction pending, `cl3_o` inverts on every master clock. `cl3_en_o` is high exactly in the cycles where `cl3_o` is high and is about to fall, so it is never high in two consecutive cycles.
- R3: `hsync_i` and `vsync_i` are registered twice. A low-to-high transition takes effect at the clock edge after the one that first samples the high level. Each horizontal edge toggles `odd_line_o`, unless it performs a resync. Without a horizontal edge, `odd_line_o` does not change.
- R4: A horizontal edge that arrives while `odd_line_o` is 1 and no resync is armed freezes `cl3_o` for exactly one extra master cycle and suppresses `cl3_en_o` in that cycle.
- R5: A vertical edge arms a resync. The next horizontal edge clears `odd_line_o` and the line index to 0, inserts no freeze, and consumes the arm. A vertical edge in the same cycle as that horizontal edge re-arms.
- R6: After `run_i` rises, `line_start_o` stays zero until the first resync edge.
- R7: On the resync line, both start bits fire. After that, `line_start_o[0]` (2-line store) fires on lines whose index is even, and `line_start_o[1]` (4-line store) fires on lines whose index is 0 modulo 4. The index counts horizontal edges from the resync line.
- R8: Each start pulse begins at the clock edge that applies the horizontal edge and lasts `STROBE_LEN` master cycles (default 2, one nominal system clock period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 6x subcarrier |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run-enable from mode controller; low means bypass |
| hsync_i | input | 1 | Horizontal sync detect level |
| vsync_i | input | 1 | Vertical sync detect level |
| cl3_o | output | 1 | Divided system clock level |
| cl3_en_o | output | 1 | One-cycle enable per system clock period |
| odd_line_o | output | 1 | Odd/even line flag |
| line_start_o | output | LINE_W | Start strobes; bit 0 for the 2-line store, bit 1 for the 4-line store |

## Verification
If the line flag holds the wrong value, the one-cycle freeze lands on the wrong lines. `cl3_o` then diverges from the expected phase within a master cycle of the next horizontal edge, and the error persists. A wrong line index or a lost resync arm shows up as a missing or extra start bit at the next line start, or at the latest at the first line after the next vertical edge. A strobe length or gating fault is visible within the `STROBE_LEN` cycles that follow the horizontal edge concerned.

// File: rtl/scd_pkg.sv
package scd_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} cl3_ph_e;

  function automatic cl3_ph_e ph_flip(cl3_ph_e p);
    return (p == PH_HIGH) ? PH_LOW : PH_HIGH;
  endfunction
endpackage

// File: rtl/scd_edge_det.sv
module scd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic d1_q, d2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= 1'b0;
      d2_q <= 1'b0;
    end else begin
      d1_q <= lvl_i;
      d2_q <= d1_q;
    end
  end

  assign rise_o = d1_q & ~d2_q;

  // R3
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/scd_divider.sv
module scd_divider
  import scd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_i,
  output logic cl3_o,
  output logic cl3_en_o
);
  cl3_ph_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= PH_LOW;
    else if (!run_i)  ph_q <= PH_LOW;
    else if (!hold_i) ph_q <= ph_flip(ph_q);
  end

  assign cl3_o    = (ph_q == PH_HIGH);
  assign cl3_en_o = run_i & cl3_o & ~hold_i;

  // R2
  en_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl3_en_o |=> !cl3_en_o);
  // R4
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i) |=> (cl3_o == $past(cl3_o)));
endmodule

// File: rtl/scd_line_phase.sv
module scd_line_phase #(
  parameter int LINE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              hs_edge_i,
  input  logic              vs_edge_i,
  output logic              odd_o,
  output logic              hold_o,
  output logic              tick_o,
  output logic              gate_o,
  output logic              synced_o,
  output logic [LINE_W-1:0] line_nxt_o
);
  logic              armed_q, odd_q, synced_q;
  logic [LINE_W-1:0] idx_q;
  logic              resync;

  assign tick_o     = run_i & hs_edge_i;
  assign resync     = tick_o & armed_q;
  assign hold_o     = tick_o & odd_q & ~armed_q;
  assign gate_o     = resync | synced_q;
  assign line_nxt_o = armed_q ? '0 : idx_q + LINE_W'(1);
  assign odd_o      = odd_q;
  assign synced_o   = synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      odd_q    <= 1'b0;
      synced_q <= 1'b0;
      idx_q    <= '0;
    end else if (!run_i) begin
      armed_q  <= 1'b0;
      odd_q    <= 1'b0;
      synced_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      armed_q <= vs_edge_i | (armed_q & ~hs_edge_i);
      if (hs_edge_i) begin
        idx_q <= line_nxt_o;
        if (armed_q) begin
          odd_q    <= 1'b0;
          synced_q <= 1'b1;
        end else begin
          odd_q <= ~odd_q;
        end
      end
    end
  end

  // R3
  odd_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hs_edge_i) |=> $stable(odd_q));
  // R4
  hold_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (odd_q && !armed_q));
  // R5
  resync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync |=> (!odd_q && idx_q == '0 && synced_q));
endmodule

// File: rtl/scd_start_strobe.sv
module scd_start_strobe #(
  parameter int LINE_W     = 2,
  parameter int STROBE_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic [LINE_W-1:0] line_nxt_i,
  output logic [LINE_W-1:0] start_o
);
  localparam int CNT_W = $clog2(STROBE_LEN + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] bits_q, tap_hit;

  // tap k serves a store of 2^(k+1) lines
  for (genvar k = 0; k < LINE_W; k++) begin : g_tap
    assign tap_hit[k] = (line_nxt_i[k:0] == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else if (tick_i && gate_i) begin
      cnt_q  <= CNT_W'(STROBE_LEN);
      bits_q <= tap_hit;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign start_o = (cnt_q != '0) ? bits_q : '0;

  // R7
  for (genvar k = 1; k < LINE_W; k++) begin : g_nest_chk
    nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[k] |-> start_o[k-1]);
  end
endmodule

// File: rtl/subcarrier_clk_div.sv
module subcarrier_clk_div #(
  parameter int LINE_W     = 2,
  parameter int STROBE_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic              cl3_o,
  output logic              cl3_en_o,
  output logic              odd_line_o,
  output logic [LINE_W-1:0] line_start_o
);
  logic              hs_edge, vs_edge, hold, tick, gate, synced;
  logic [LINE_W-1:0] line_nxt;

  scd_edge_det u_hs (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(hsync_i), .rise_o(hs_edge));
  scd_edge_det u_vs (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(vsync_i), .rise_o(vs_edge));

  scd_line_phase #(.LINE_W(LINE_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .hs_edge_i(hs_edge), .vs_edge_i(vs_edge),
    .odd_o(odd_line_o), .hold_o(hold), .tick_o(tick),
    .gate_o(gate), .synced_o(synced), .line_nxt_o(line_nxt)
  );

  scd_divider u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .hold_i(hold),
    .cl3_o(cl3_o), .cl3_en_o(cl3_en_o)
  );

  scd_start_strobe #(.LINE_W(LINE_W), .STROBE_LEN(STROBE_LEN)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_i(tick),
    .gate_i(gate), .line_nxt_i(line_nxt), .start_o(line_start_o)
  );

  // R1
  bypass_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!cl3_o && !odd_line_o && line_start_o == '0));
  // R6
  gated_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o != '0) |-> synced);
endmodule

// File: tb/sim_subcarrier_clk_div.sv
module sim_subcarrier_clk_div;
  localparam int LW = 2;
  localparam int SL = 2;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, hs = 1'b0, vs = 1'b0;
  logic cl3, cl3_en, odd;
  logic [LW-1:0] start;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  subcarrier_clk_div #(.LINE_W(LW), .STROBE_LEN(SL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .hsync_i(hs), .vsync_i(vs),
    .cl3_o(cl3), .cl3_en_o(cl3_en), .odd_line_o(odd), .line_start_o(start)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // behavioural reference
  int m_hs1, m_hs2, m_vs1, m_vs2, m_ph, m_odd, m_arm, m_syn, m_idx, m_cnt, m_b0, m_b1;
  int m_run_used, m_held, m_resynced, w0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hs1 = 0; m_hs2 = 0; m_vs1 = 0; m_vs2 = 0; m_ph = 0; m_odd = 0; m_arm = 0;
      m_syn = 0; m_idx = 0; m_cnt = 0; m_b0 = 0; m_b1 = 0; w0 = 0;
    end else begin
      int he, ve;
      he = (m_hs1 == 1 && m_hs2 == 0);
      ve = (m_vs1 == 1 && m_vs2 == 0);
      m_run_used = run;
      m_held = 0;
      m_resynced = 0;
      if (!run) begin
        m_ph = 0; m_odd = 0; m_arm = 0; m_syn = 0; m_idx = 0; m_cnt = 0; m_b0 = 0; m_b1 = 0;
      end else begin
        int allow;
        allow = he && (m_arm || m_syn);
        if (he && m_odd && !m_arm) m_held = 1;
        if (!m_held) m_ph = 1 - m_ph;
        if (he) begin
          if (m_arm) begin
            m_odd = 0; m_idx = 0; m_syn = 1; m_resynced = 1;
          end else begin
            m_odd = 1 - m_odd; m_idx = (m_idx + 1) % 4;
          end
        end
        m_arm = (ve || (m_arm && !he)) ? 1 : 0;
        if (allow) begin
          m_cnt = SL; m_b0 = (m_idx % 2 == 0); m_b1 = (m_idx % 4 == 0);
        end else if (m_cnt > 0) m_cnt--;
      end
      m_hs2 = m_hs1; m_hs1 = hs; m_vs2 = m_vs1; m_vs1 = vs;
    end
    #2;
    if (rst_n && !done) begin
      int he2, hold_now, e_en, e_s;
      he2 = (m_hs1 == 1 && m_hs2 == 0);
      hold_now = run && he2 && m_odd && !m_arm;
      e_en = (run && m_ph && !hold_now) ? 1 : 0;
      e_s = (m_cnt > 0) ? (m_b1 * 2 + m_b0) : 0;
      if (!m_run_used) begin
        chk("R1", "cl3", cl3, 0);
        chk("R1", "odd", odd, 0);
        chk("R1", "start", start, 0);
      end else begin
        chk(m_held ? "R4" : "R2", "cl3", cl3, m_ph);
        chk(m_resynced ? "R5" : "R3", "odd", odd, m_odd);
        chk(m_syn ? "R7" : "R6", "start", start, e_s);
      end
      chk(run ? "R2" : "R1", "cl3_en", cl3_en, e_en);
      if (!m_run_used) w0 = 0;
      else if (start[0]) w0++;
      else if (w0 != 0) begin
        chk("R8", "strobe width", w0, SL);
        w0 = 0;
      end
    end
  end

  task automatic line(input int len, input int hw, input int vs_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hs = (i < hw);
      if (vs_at >= 0) vs = (i >= vs_at && i < vs_at + 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset cl3", cl3, 0);
    chk("R1", "reset en", cl3_en, 0);
    chk("R1", "reset odd", odd, 0);
    chk("R1", "reset start", start, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;
    for (int l = 0; l < 5; l++) line(20, 4, -1);
    line(20, 4, 8);
    for (int l = 0; l < 10; l++) line(23, 4, -1);
    @(negedge clk); hs = 1; vs = 1;
    repeat (4) @(negedge clk); hs = 0; vs = 0;
    repeat (15) @(negedge clk);
    for (int l = 0; l < 8; l++) line(21, 2, -1);
    line(20, 4, 6);
    for (int l = 0; l < 3; l++) line(22, 4, -1);
    run = 1'b0;
    repeat (10) @(negedge clk);
    run = 1'b1;
    for (int l = 0; l < 3; l++) line(19, 3, -1);
    line(19, 3, 10);
    for (int l = 0; l < 9; l++) line(17, 1, -1);
    line(24, 5, 12);
    for (int l = 0; l < 12; l++) line(25, 4, -1);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule